// File: doc/BRIEF.md
# Sixteen-Bit PC-Style I/O Bus Bridge

This block connects a 32-bit processor access port to an external 16-bit PC-style I/O bus. A request is decoded against five address regions. Each region drives its own chip select. A hit runs a fixed-length bus cycle whose length comes from a 2-bit cycle-type field held for that region. The cycle is timed in ticks of a 16 MHz reference. That reference is derived from the system clock by dividing it by `TICK_DIV`. The tick divider restarts at the start of every access, so every phase boundary falls a whole number of ticks after the request.

The low half-word of the processor data goes straight onto the I/O bus. Two control outputs let external latches carry the upper half-word: one for writes and one for reads. Two extra inputs let external logic move a full word over the 16-bit bus. The first input captures a bus half-word into an internal holding register on a read, and swaps the driven half on a write. The second input makes the read result take its upper half from that holding register instead of from the extension latches. A request that hits no region is acknowledged at once, with read data of zero and no bus activity.

Top module: `pcio_bridge`

## Requirements
- R1: Region decode on the top address nibble `addr[23:20]`. Values 0 to 3 select region 0, which is the largest region. Values 4, 5, 6 and 7 select regions 1 to 4. Only bit `io_cs[i]` of the selected region is asserted, and it stays constant for the whole access.
- R2: A request whose top nibble is 8 to 15 asserts `ack` in the cycle after the request is taken. It asserts no chip select and no strobe. A read returns `rdata` = 0.
- R3: The strobe of region `i` lasts `len * TICK_DIV` clock cycles when `io_ready` is high. The length `len` comes from `cfg_cycle[2i+1:2i]`: 00 gives 2 ticks, 01 gives 3, 10 gives 4 and 11 gives 6.
- R4: For region 0, cycle-type values 10 and 11 are treated as 01, which gives 3 ticks.
- R5: `io_ready` is sampled at the last tick of the strobe. While it is low, the strobe is extended by whole ticks and ends at the first tick boundary at which `io_ready` is high.
- R6: The chip select rises exactly one tick (`TICK_DIV` cycles) before the strobe and falls one tick after it.
- R7: A write asserts only `io_wr` and a read asserts only `io_rd`. Neither strobe is ever asserted without a chip select.
- R8: `ack` is high for exactly one cycle. It rises in the cycle after the chip select falls.
- R9: During a write strobe, `io_dout` carries `wdata[15:0]`, `xl_dout` carries `wdata[31:16]`, and `xl_le` follows `io_wr`. `xl_oe` follows `io_rd`.
- R10: A read returns `io_din` in `rdata[15:0]` and `xl_din` in `rdata[31:16]`, both as they were at the completing tick.
- R11: While `pair_cap` is high during a write, `io_dout` carries `wdata[31:16]` instead of the low half.
- R12: During a read strobe, each tick with `pair_cap` high loads `io_din` into a holding register, which is cleared at the start of each access. If `pair_sel` is high at completion, `rdata[31:16]` comes from that register instead of from `xl_din`.
- R13: After reset, `ack`, `io_cs`, `io_rd`, `io_wr` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held high until `ack` |
| addr | input | 24 | Access address |
| we | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid from `ack` until the next access |
| ack | output | 1 | One-cycle completion pulse |
| cfg_cycle | input | 10 | Cycle-type field, 2 bits per region |
| io_cs | output | 5 | Chip selects, one per region |
| io_rd | output | 1 | Read strobe |
| io_wr | output | 1 | Write strobe |
| io_ready | input | 1 | External ready; low stretches the strobe |
| io_dout | output | 16 | I/O bus write data |
| io_din | input | 16 | I/O bus read data |
| xl_dout | output | 16 | Upper half-word toward the extension latches |
| xl_din | input | 16 | Upper half-word from the extension latches |
| xl_le | output | 1 | Extension latch load enable (write) |
| xl_oe | output | 1 | Extension latch drive enable (read) |
| pair_cap | input | 1 | Word-pairing capture / write half swap |
| pair_sel | input | 1 | Take the read upper half from the holding register |

## Verification
Counting from the edge that takes the request, the chip select appears one cycle later and the strobe follows `TICK_DIV` cycles after it. `ack` arrives exactly `2*TICK_DIV + strobe length` cycles after the chip select rises. An unmapped request is acknowledged in the very next cycle. The bench samples every output on the falling edge and counts chip-select and strobe cycles per access. From those counts it derives the lead, the trail and the ack position, and it compares them with lengths computed from the cycle-type table and the cycle in which `io_ready` was raised. Read data is checked at the `ack` cycle, and the one-cycle pulse is checked on the falling edge that follows.

// File: rtl/pcio_pkg.sv
package pcio_pkg;

    localparam int NREG    = 5;
    localparam int IDX_W   = 3;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int LEN_W   = 3;
    localparam int BIG_REG = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_ACK
    } seq_st_e;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic              we;
        logic [WORD_W-1:0] wdata;
        logic [LEN_W-1:0]  len;
    } acc_t;

    // Region 0 (largest) only offers the two shortest types.
    function automatic logic [1:0] eff_code(input logic [IDX_W-1:0] idx,
                                            input logic [1:0] code);
        if (idx == IDX_W'(BIG_REG) && code[1])
            return 2'b01;
        return code;
    endfunction

    function automatic logic [LEN_W-1:0] ticks_of(input logic [1:0] code);
        case (code)
            2'b00:   return LEN_W'(2);
            2'b01:   return LEN_W'(3);
            2'b10:   return LEN_W'(4);
            default: return LEN_W'(6);
        endcase
    endfunction

endpackage

// File: rtl/pcio_decode.sv
module pcio_decode
    import pcio_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [NREG-1:0] match;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == BIG_REG) begin : g_big
            localparam logic [ADDR_W-1:0] MASK = {2'b11, {(ADDR_W-2){1'b0}}};
            localparam logic [ADDR_W-1:0] BASE = '0;
            assign match[i] = (addr & MASK) == BASE;
        end else begin : g_small
            localparam logic [ADDR_W-1:0] MASK = {4'hF, {(ADDR_W-4){1'b0}}};
            localparam logic [ADDR_W-1:0] BASE = {4'(3 + i), {(ADDR_W-4){1'b0}}};
            assign match[i] = (addr & MASK) == BASE;
        end
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--)
            if (match[i]) idx = IDX_W'(i);
    end
endmodule

// File: rtl/pcio_tick.sv
module pcio_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pcio_seq.sv
module pcio_seq
    import pcio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             hit,
    input  logic [LEN_W-1:0] len,
    input  logic             ready,
    input  logic             tick,
    output logic             take,
    output logic             run,
    output logic             strobe,
    output logic             fin,
    output logic             ack
);
    seq_st_e          st;
    logic [LEN_W-1:0] scnt;
    logic             last;

    assign take   = (st == ST_IDLE) && req;
    assign run    = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
    assign strobe = (st == ST_STROBE);
    assign ack    = (st == ST_ACK);
    assign last   = (scnt == len - 1'b1);
    assign fin    = strobe && tick && last && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            scnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    scnt <= '0;
                    if (req) st <= hit ? ST_SETUP : ST_ACK;
                end
                ST_SETUP: if (tick) st <= ST_STROBE;
                ST_STROBE: begin
                    if (tick) begin
                        if (!last)
                            scnt <= scnt + 1'b1;
                        else if (ready)
                            st <= ST_HOLD;
                    end
                end
                ST_HOLD: if (tick) st <= ST_ACK;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pcio_steer.sv
module pcio_steer
    import pcio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              miss,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              strobe,
    input  logic              tick,
    input  logic              fin,
    input  logic              pair_cap,
    input  logic              pair_sel,
    input  logic [HALF_W-1:0] io_din,
    input  logic [HALF_W-1:0] xl_din,
    output logic [WORD_W-1:0] rdata,
    output logic [HALF_W-1:0] io_dout,
    output logic [HALF_W-1:0] xl_dout
);
    logic [HALF_W-1:0] hold;

    assign io_dout = pair_cap ? wdata[WORD_W-1:HALF_W] : wdata[HALF_W-1:0];
    assign xl_dout = wdata[WORD_W-1:HALF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            rdata <= '0;
        end else begin
            if (take) begin
                hold <= '0;
                if (miss) rdata <= '0;
            end else if (strobe && tick && !we && pair_cap) begin
                hold <= io_din;
            end
            if (fin && !we)
                rdata <= {pair_sel ? hold : xl_din, io_din};
        end
    end
endmodule

// File: rtl/pcio_bridge.sv
module pcio_bridge
    import pcio_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int TICK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                ack,
    input  logic [2*NREG-1:0]   cfg_cycle,
    output logic [NREG-1:0]     io_cs,
    output logic                io_rd,
    output logic                io_wr,
    input  logic                io_ready,
    output logic [HALF_W-1:0]   io_dout,
    input  logic [HALF_W-1:0]   io_din,
    output logic [HALF_W-1:0]   xl_dout,
    input  logic [HALF_W-1:0]   xl_din,
    output logic                xl_le,
    output logic                xl_oe,
    input  logic                pair_cap,
    input  logic                pair_sel
);
    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic             take, run, strobe, fin, tick;
    acc_t             acc;
    logic [1:0]       raw_code;

    pcio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    assign raw_code = cfg_cycle[2*dec_idx +: 2];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (take) begin
            acc.hit   <= dec_hit;
            acc.idx   <= dec_idx;
            acc.we    <= we;
            acc.wdata <= wdata;
            acc.len   <= ticks_of(eff_code(dec_idx, raw_code));
        end
    end

    pcio_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    pcio_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .hit    (dec_hit),
        .len    (acc.len),
        .ready  (io_ready),
        .tick   (tick),
        .take   (take),
        .run    (run),
        .strobe (strobe),
        .fin    (fin),
        .ack    (ack)
    );

    pcio_steer u_steer (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .miss     (!dec_hit),
        .we       (acc.we),
        .wdata    (acc.wdata),
        .strobe   (strobe),
        .tick     (tick),
        .fin      (fin),
        .pair_cap (pair_cap),
        .pair_sel (pair_sel),
        .io_din   (io_din),
        .xl_din   (xl_din),
        .rdata    (rdata),
        .io_dout  (io_dout),
        .xl_dout  (xl_dout)
    );

    always_comb begin
        io_cs = '0;
        if (run) io_cs[acc.idx] = 1'b1;
    end

    assign io_rd = strobe && !acc.we;
    assign io_wr = strobe && acc.we;
    assign xl_le = io_wr;
    assign xl_oe = io_rd;
endmodule

// File: rtl/pcio_chk.sv
module pcio_chk (
    input logic       clk,
    input logic       rst,
    input logic       ack,
    input logic [4:0] io_cs,
    input logic       io_rd,
    input logic       io_wr,
    input logic       io_ready
);
    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(io_cs));

    p_cs_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (|io_cs) |=> (io_cs == $past(io_cs)) || (io_cs == '0));

    p_stretch_ready_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(io_rd) || $fell(io_wr)) |-> $past(io_ready));

    p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (rst)
        (io_rd || io_wr) |-> (|io_cs));

    p_one_dir_r7: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && io_wr));

    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_ack_idle_r8: assert property (@(posedge clk) disable iff (rst)
        ack |-> (io_cs == '0));
endmodule

bind pcio_bridge pcio_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack),
    .io_cs    (io_cs),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_ready (io_ready)
);

// File: tb/tb_pcio_bridge.sv
`timescale 1ns/1ps
module tb_pcio_bridge;
    localparam int DIV   = 4;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        req = 0;
    logic [23:0] addr = '0;
    logic        we = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic [9:0]  cfg_cycle = '0;
    logic [4:0]  io_cs;
    logic        io_rd, io_wr;
    logic        io_ready = 1;
    logic [15:0] io_dout, xl_dout;
    logic [15:0] io_din = '0, xl_din = '0;
    logic        xl_le, xl_oe;
    logic        pair_cap = 0, pair_sel = 0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pcio_bridge #(.ADDR_W(24), .TICK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .ack(ack), .cfg_cycle(cfg_cycle), .io_cs(io_cs),
        .io_rd(io_rd), .io_wr(io_wr), .io_ready(io_ready), .io_dout(io_dout),
        .io_din(io_din), .xl_dout(xl_dout), .xl_din(xl_din), .xl_le(xl_le),
        .xl_oe(xl_oe), .pair_cap(pair_cap), .pair_sel(pair_sel)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int exp_ticks(input int rg, input logic [1:0] code);
        logic [1:0] c;
        c = (rg == 0 && code[1]) ? 2'b01 : code;
        case (c)
            2'b00:   return 2;
            2'b01:   return 3;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    // rg < 0 selects an unmapped address
    task automatic do_access(input int rg, input bit wr, input int kready, input bit pair);
        logic [23:0] a;
        logic [31:0] wd;
        logic [15:0] lo, hi, xv;
        int cyc = 0, ncs = 0, nstb = 0, first_cs = -1, first_stb = -1, ack_at = -1;
        bit cs_ok = 1, dir_ok = 1, dout_ok = 1, ctl_ok = 1, pc = 0;
        logic [31:0] got = '0, expd;
        int len, exp_stb, kt;

        a[19:0] = 20'($urandom);
        if (rg < 0)       a[23:20] = 4'(8 + $urandom_range(0, 7));
        else if (rg == 0) a[23:20] = 4'($urandom_range(0, 3));
        else              a[23:20] = 4'(3 + rg);
        wd = $urandom;
        lo = 16'($urandom);
        hi = 16'($urandom);
        xv = 16'($urandom);

        addr = a; we = wr; wdata = wd; req = 1;
        io_ready = (kready == 0);
        pair_sel = pair; pair_cap = 0;
        io_din = lo; xl_din = xv;

        while (ack_at < 0 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (|io_cs) begin
                ncs++;
                if (first_cs < 0) first_cs = cyc;
                if (rg < 0 || io_cs != 5'(1 << rg)) cs_ok = 0;
            end
            if (xl_le !== io_wr || xl_oe !== io_rd) ctl_ok = 0;
            if (io_rd || io_wr) begin
                nstb++;
                if (first_stb < 0) first_stb = cyc;
                if (io_wr !== wr || io_rd !== !wr) dir_ok = 0;
                if (wr && (io_dout !== (pc ? wd[31:16] : wd[15:0]) || xl_dout !== wd[31:16]))
                    dout_ok = 0;
                if (kready > 0 && nstb == kready) io_ready = 1;
                if (pair && nstb == 1)       begin pc = 1; pair_cap = 1; io_din = hi; end
                if (pair && nstb == DIV + 1) begin pc = 0; pair_cap = 0; io_din = lo; end
            end
            if (ack) begin
                ack_at = cyc;
                got = rdata;
                req = 0;
            end
        end
        @(negedge clk);
        chk(ack === 1'b0 && io_cs === 5'd0, "R8", "ack pulse one cycle", {ack, io_cs}, 0);
        pair_cap = 0; io_ready = 1;

        if (rg < 0) begin
            chk(ncs == 0 && nstb == 0, "R2", "unmapped bus activity", ncs + nstb, 0);
            chk(ack_at == 1, "R2", "unmapped ack cycle", ack_at, 1);
            if (!wr) chk(got == 0, "R2", "unmapped rdata", got, 0);
        end else begin
            len = exp_ticks(rg, cfg_cycle[2*rg +: 2]);
            kt = (kready + DIV - 1) / DIV;
            exp_stb = DIV * ((kt > len) ? kt : len);
            chk(cs_ok && ncs > 0, "R1", "chip select", io_cs, 1 << rg);
            if (kready > 0)
                chk(nstb == exp_stb, "R5", "stretched strobe cycles", nstb, exp_stb);
            else if (rg == 0)
                chk(nstb == exp_stb, "R4", "region0 strobe cycles", nstb, exp_stb);
            else
                chk(nstb == exp_stb, "R3", "strobe cycles", nstb, exp_stb);
            chk(first_stb - first_cs == DIV && ncs == nstb + 2 * DIV, "R6", "cs lead/trail",
                ncs, nstb + 2 * DIV);
            chk(dir_ok, "R7", "strobe direction", wr, wr);
            chk(ack_at == first_cs + ncs, "R8", "ack position", ack_at, first_cs + ncs);
            chk(ctl_ok, "R9", "latch controls follow strobes", 0, 0);
            if (wr) begin
                if (pair) chk(dout_ok, "R11", "paired write io_dout", 0, 0);
                else      chk(dout_ok, "R9", "write data halves", 0, 0);
            end else begin
                expd = {pair ? hi : xv, lo};
                if (pair) chk(got == expd, "R12", "paired read rdata", got, expd);
                else      chk(got == expd, "R10", "read rdata", got, expd);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ack === 0 && io_cs === 0 && io_rd === 0 && io_wr === 0 && rdata === 0,
            "R13", "reset state", {ack, io_cs, io_rd, io_wr}, 0);

        // R3: every cycle type on region 1
        for (int c = 0; c < 4; c++) begin
            cfg_cycle = 10'(c << 2);
            do_access(1, c[0], 0, 0);
        end
        // R4: clamped types on the big region
        cfg_cycle = 10'b10;
        do_access(0, 0, 0, 0);
        cfg_cycle = 10'b11;
        do_access(0, 1, 0, 0);
        // R5: ready held low past the nominal end
        cfg_cycle = 10'h000;
        do_access(3, 0, 13, 0);
        do_access(4, 1, 8, 0);
        // R11, R12: word pairing
        cfg_cycle = 10'h3FF;
        do_access(2, 0, 0, 1);
        do_access(2, 1, 0, 1);
        // R2: unmapped
        do_access(-1, 0, 0, 0);
        do_access(-1, 1, 0, 0);

        for (int i = 0; i < 40; i++) begin
            int rg;
            cfg_cycle = 10'($urandom);
            rg = $urandom_range(0, 5) - 1;
            do_access(rg, 1'($urandom), ($urandom_range(0, 2) == 0) ? $urandom_range(1, 30) : 0,
                      1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule